// File: doc/BRIEF.md
# Event-Count Triggered Constant Frame Serializer

This block watches an asynchronous event line and counts its pulses. On every fifth event it sends an 8-bit frame that holds the fixed value five out of a single serial pin. Reaching the terminal count does two things at once. It fires an active-low strobe that captures the constant byte in a parallel-in, serial-out register, and it sends the event counter back to zero.

A set/reset busy flag is raised when the byte is captured. While that flag is up, shift-rate ticks are passed to the register. The system provides these ticks as one-cycle pulses, nominally at 100 kHz. Exactly eight ticks pass per frame. The eighth one clears the flag and stops the shifting. Zeros fill the register behind the data.

Events that arrive during a frame are still counted. A count that reaches five during a frame is held, and the next frame starts as soon as the current one ends.

Top module: `evtFrameSerializer`

## Requirements
- R1: While reset is asserted and right after it is released, serOut is 0 and busy is 0. Ticks applied before any event leave serOut at 0.
- R2: Each low-to-high transition of evtIn counts as exactly one event, as long as each level is held for at least two clock cycles. A level held high for a long time counts once. Four events alone never start a frame.
- R3: When the count reaches five while busy is low, the register captures the byte 8'b0000_0101 and busy rises. This happens no later than five clock cycles after the rising edge on evtIn.
- R4: The load that starts a frame also sets the event counter back to zero. A new frame therefore needs five more events.
- R5: Bits leave the register MSB first. After k gated ticks of a frame (k = 0..7), serOut shows bit 7-k of the byte. Across one frame the tick-sampled sequence is 0,0,0,0,0,1,0,1.
- R6: Exactly eight ticks are gated per frame. busy falls on the clock edge that takes the eighth tick. Once the frame ends, serOut is 0 because zeros have shifted in behind the data.
- R7: A shiftTick that arrives while busy is low has no effect, and serOut stays 0.
- R8: Events that arrive while busy is high are still counted. The count stops at five, and any further events in that frame are dropped. When the frame ends with the count at five, the next frame loads on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 1 | Asynchronous event line; each rising edge is one event |
| shiftTick | input | 1 | One-cycle shift-rate tick |
| serOut | output | 1 | Serial frame output, MSB first |
| busy | output | 1 | High while a frame is being shifted out |

## Verification
The bench targets three corner cases.

- **Long-held event level.** The bench holds evtIn high for many cycles, then checks that this counts as one event. A design that counts levels instead of edges starts a frame early.
- **Counter clear and dropped events.** It sends six events during a single frame, then four after that frame. A counter that is not cleared by the load, or one that keeps counting past five, produces a frame the scoreboard never predicted.
- **Bit order and tick count.** Every gated tick is compared against the expected MSB-first bit sequence, and the number of ticks per frame must be exactly eight. Reversed bit order, or a flag that clears one tick early or late, shows up as a wrong bit, a wrong count, or a nonzero level after busy falls.

// File: rtl/evtSerPkg.sv
package evtSerPkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadN;     // active-low parallel capture of the constant byte
    logic clrCount;  // return the event counter to zero
    logic shiftEn;   // one gated shift step
  } serCtl_t;

endpackage

// File: rtl/evtSerDatapath.sv
module evtSerDatapath
  import evtSerPkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter int                    TERM_COUNT  = 5,
  parameter int                    FRAME_BITS  = 8,
  parameter logic [FRAME_BITS-1:0] LOAD_VALUE  = FRAME_BITS'(5)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    evtIn,
  input  serCtl_t ctl,
  output logic    atTerm,
  output logic    lastBit,
  output logic    serOut
);

  localparam int CNT_W = $clog2(TERM_COUNT + 1);
  localparam int BIT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] TERM_VAL = CNT_W'(TERM_COUNT);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);

  // Synchronizer chain for the asynchronous event line
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   evtPrev;
  logic                   evtRise;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= evtIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPrev <= 1'b0;
    else       evtPrev <= syncQ[SYNC_STAGES-1];
  end

  assign evtRise = syncQ[SYNC_STAGES-1] & ~evtPrev;

  // Event counter: holds at the terminal value, cleared by the load decode.
  // An event seen in the clearing cycle becomes the first of the next group.
  logic [CNT_W-1:0] evtCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCount <= '0;
    end else if (ctl.clrCount) begin
      evtCount <= evtRise ? CNT_W'(1) : '0;
    end else if (evtRise && (evtCount != TERM_VAL)) begin
      evtCount <= evtCount + CNT_W'(1);
    end
  end

  assign atTerm = (evtCount == TERM_VAL);

  // Parallel-in serial-out register, serial input tied low
  logic [FRAME_BITS-1:0] shReg;
  logic [BIT_W-1:0]      bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (!ctl.loadN) begin
      shReg  <= LOAD_VALUE;
      bitCnt <= '0;
    end else if (ctl.shiftEn) begin
      shReg  <= {shReg[FRAME_BITS-2:0], 1'b0};
      bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  assign lastBit = (bitCnt == LAST_IDX);
  assign serOut  = shReg[FRAME_BITS-1];

  // R8
  term_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtCount <= TERM_VAL);

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadN |=> (shReg == LOAD_VALUE));

  // R4
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCount |=> (evtCount <= CNT_W'(1)));

  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> (shReg[0] == 1'b0));

endmodule

// File: rtl/evtSerControl.sv
module evtSerControl
  import evtSerPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    atTerm,
  input  logic    lastBit,
  input  logic    shiftTick,
  output serCtl_t ctl,
  output logic    busy
);

  logic loadReq;

  // Terminal-count decode, held off while a frame is in flight
  assign loadReq = atTerm & ~busy;

  always_comb begin
    ctl          = '0;
    ctl.loadN    = ~loadReq;
    ctl.clrCount = loadReq;
    ctl.shiftEn  = busy & shiftTick;
  end

  // Set/reset gating flag: set by the load, reset after the last bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         busy <= 1'b0;
    else if (loadReq)                  busy <= 1'b1;
    else if (ctl.shiftEn && lastBit)   busy <= 1'b0;
  end

  // R3
  busy_rise_on_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(atTerm));

  // R6
  busy_fall_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(shiftTick) && $past(lastBit)));

endmodule

// File: rtl/evtFrameSerializer.sv
module evtFrameSerializer
  import evtSerPkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter int                    TERM_COUNT  = 5,
  parameter int                    FRAME_BITS  = 8,
  parameter logic [FRAME_BITS-1:0] LOAD_VALUE  = FRAME_BITS'(5)
) (
  input  logic clk,
  input  logic rstN,
  input  logic evtIn,
  input  logic shiftTick,
  output logic serOut,
  output logic busy
);

  serCtl_t ctl;
  logic    atTerm;
  logic    lastBit;

  evtSerControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .atTerm    (atTerm),
    .lastBit   (lastBit),
    .shiftTick (shiftTick),
    .ctl       (ctl),
    .busy      (busy)
  );

  evtSerDatapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .TERM_COUNT  (TERM_COUNT),
    .FRAME_BITS  (FRAME_BITS),
    .LOAD_VALUE  (LOAD_VALUE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .ctl     (ctl),
    .atTerm  (atTerm),
    .lastBit (lastBit),
    .serOut  (serOut)
  );

endmodule

// File: tb/evtFrameSerializer_tb.sv
module evtFrameSerializer_tb;

  localparam int TICK_DIV = 10;
  localparam logic [7:0] FRAME_BYTE = 8'b0000_0101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtIn = 1'b0;
  logic shiftTick = 1'b0;
  logic serOut;
  logic busy;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic expQ[$];
  int   tickInFrame = 0;
  int   framesSeen = 0;
  logic busyPrev = 1'b0;

  always #4 clk = ~clk;

  evtFrameSerializer u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .shiftTick (shiftTick),
    .serOut    (serOut),
    .busy      (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Free-running shift-rate tick, driven just after the rising edge
  initial begin
    int div = 0;
    forever begin
      @(posedge clk); #1;
      shiftTick = (div == TICK_DIV - 1);
      div = (div == TICK_DIV - 1) ? 0 : div + 1;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulseEvent(input int hi, input int lo);
    evtIn = 1'b1;
    step(hi);
    evtIn = 1'b0;
    step(lo);
  endtask

  // Driver side of the scoreboard: predict one frame, MSB first
  task automatic expectFrame();
    for (int b = 7; b >= 0; b--) expQ.push_back(FRAME_BYTE[b]);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (busy && !busyPrev) begin
        framesSeen++;
        tickInFrame = 0;
        // R3 a frame starts only when one was predicted
        check(expQ.size() >= 8, "R3 unexpected frame start", expQ.size(), 8);
      end
      if (busy && shiftTick) begin
        tickInFrame++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 serial bit with empty scoreboard", serOut, 0);
        end else begin
          logic e;
          e = expQ.pop_front();
          check(serOut == e, "R5 serial bit order", serOut, e);
        end
      end
      if (!busy && busyPrev) begin
        check(tickInFrame == 8, "R6 ticks per frame", tickInFrame, 8);
        check(serOut == 1'b0, "R6 zero fill after frame", serOut, 0);
      end
      if (!busy && !busyPrev && shiftTick) begin
        check(serOut == 1'b0, "R7 idle tick has no effect", serOut, 0);
      end
      busyPrev = busy;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(3);
    @(negedge clk);
    check(serOut == 1'b0, "R1 serOut in reset", serOut, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rstN = 1'b1;
    step(25);
    @(negedge clk);
    check(serOut == 1'b0 && busy == 1'b0, "R1 idle after reset", {busy, serOut}, 0);

    // Scenario A: four events alone, then the fifth
    for (int i = 0; i < 4; i++) pulseEvent(3, 3);
    step(20);
    @(negedge clk);
    check(busy == 1'b0, "R2 four events start no frame", busy, 0);
    expectFrame();
    pulseEvent(3, 3);
    @(negedge clk);
    check(busy == 1'b1, "R3 frame starts after fifth event", busy, 1);
    waitIdle();
    step(15);

    // Scenario B: long-held level counts once; counter was cleared (R4)
    pulseEvent(40, 3);
    for (int i = 0; i < 3; i++) pulseEvent(2, 2);
    step(20);
    @(negedge clk);
    check(busy == 1'b0, "R2 long level counts once", busy, 0);
    check(busy == 1'b0, "R4 counter cleared by load", busy, 0);
    expectFrame();
    pulseEvent(2, 3);
    @(negedge clk);
    check(busy == 1'b1, "R4 fifth fresh event loads", busy, 1);
    waitIdle();
    step(15);

    // Scenario C: events during a frame are counted, extra dropped (R8)
    for (int i = 0; i < 4; i++) pulseEvent(2, 2);
    expectFrame();
    pulseEvent(2, 3);
    @(negedge clk);
    check(busy == 1'b1, "R3 frame one of scenario C", busy, 1);
    for (int i = 0; i < 4; i++) pulseEvent(2, 2);
    expectFrame();
    pulseEvent(2, 2);
    pulseEvent(2, 2); // sixth event in this frame: dropped
    @(negedge clk);
    check(busy == 1'b1, "R8 frame still running", busy, 1);
    waitIdle();
    step(2);
    @(negedge clk);
    check(busy == 1'b1, "R8 held count loads after frame", busy, 1);
    waitIdle();
    step(5);
    for (int i = 0; i < 4; i++) pulseEvent(2, 2);
    step(30);
    @(negedge clk);
    check(busy == 1'b0, "R8 dropped event not counted", busy, 0);
    expectFrame();
    pulseEvent(2, 3);
    @(negedge clk);
    check(busy == 1'b1, "R3 final frame starts", busy, 1);
    waitIdle();
    step(30);

    @(negedge clk);
    check(framesSeen == 5, "R3 total frames", framesSeen, 5);
    check(expQ.size() == 0, "R5 all predicted bits seen", expQ.size(), 0);
    check(serOut == 1'b0, "R7 idle output", serOut, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule